// File: doc/BRIEF.md
# Dual-Channel Limit-Wrap Interval Timer

This block holds two independent interval timers behind a small word-addressed register bus. Each channel has a counter that moves forward by one on every cycle where the shared microsecond tick enable is high. It also has a programmable limit. When the next count would reach or pass a nonzero limit, the counter restarts at 1 rather than 0. That wrap latches a level interrupt for the channel. With this restart rule, a limit of L gives one interrupt every L-1 ticks, so software programs N+1 to get an N-tick period.

Count and limit values occupy the upper field of the data word, starting at bit FIELD_LSB, and the bits below read as zero. The interrupt acknowledge is a side effect of a read: an aligned read of a channel's limit word clears its pending interrupt. Because each channel has its own interrupt output and its own state, one channel can serve as a periodic system tick while the other is owned by unrelated software.

Each channel's interrupt is tracked by a two-state machine with the states IRQ_IDLE and IRQ_PENDING:
- SET moves IRQ_IDLE to IRQ_PENDING on a wrap.
- ACK moves IRQ_PENDING to IRQ_IDLE on a limit read in a cycle without a wrap.
- RELOAD moves either state to IRQ_IDLE on a limit write.
- In every other case the state holds.

Top module: `ival_timer_pair`

## Requirements
- R1: After reset each count is 1, each limit is 0, both interrupts are low and the read data is 0.
- R2: Word map by byte address: 0x0 count A, 0x4 limit A, 0x8 count B, 0xC limit B. Values are read at bits DATA_W-1:FIELD_LSB with the lower bits zero. Read data appears in the cycle after the read strobe and is 0 after any cycle without a read.
- R3: A counter moves forward by exactly one per cycle with the tick high, and holds when the tick is low.
- R4: With a nonzero limit, a tick whose incremented count is greater than or equal to the limit loads the count with 1 and is a wrap. A limit of 1 therefore wraps on every tick.
- R5: A limit of 0 never wraps and never raises the interrupt. The counter runs through its full range modulo 2^(DATA_W-FIELD_LSB).
- R6: A wrap sets the channel interrupt (bit 0 = A, bit 1 = B). The interrupt stays high through further wraps until it is cleared.
- R7: An aligned read of a limit word clears that channel's interrupt, unless the same cycle holds a wrap of that channel, in which case it stays set. Reading a count word does not clear it.
- R8: Writing a limit word stores the field, loads the count with 1 and clears the interrupt. This write takes priority over a tick or wrap in the same cycle.
- R9: Writes to count words are ignored.
- R10: The two channels run and interrupt independently from the shared tick.
- R11: An access whose byte address has nonzero bits 1:0 is ignored: it writes nothing, returns 0 and acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond advance enable |
| bus_addr | input | 4 | Byte address of the register word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data; field at DATA_W-1:FIELD_LSB |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 2 | Per-channel pending interrupt, bit 0 = A |

## Verification
The bench builds the block with DATA_W = 20 and FIELD_LSB = 10, which gives 10-bit counters. With that width, a channel with a zero limit runs its full range and rolls over to zero within about a thousand ticks, so the free-running case of R5 is checked in full. The short limits used (1, 3 and 5) make several wraps per channel cheap. They also let the bench place a wrap and a clearing read in the same cycle, and a limit write against a wrap.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int NUM_CHAN   = 2;
    localparam int CHAN_IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam int ADDR_W     = CHAN_IDX_W + 3;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    typedef enum logic {
        WORD_COUNT = 1'b0,
        WORD_LIMIT = 1'b1
    } word_kind_e;

endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             limit_on;
    logic             hit;

    always_comb begin
        count_inc = count_q + CNT_W'(1);
        limit_on  = (limit != '0);
        hit       = limit_on && (count_inc >= limit);
        wrap      = tick && hit && !reload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= RESTART;
        end else if (reload) begin
            count_q <= RESTART;
        end else if (tick) begin
            count_q <= hit ? RESTART : count_inc;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/ivt_irq_fsm.sv
module ivt_irq_fsm
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ack,
    input  logic reload,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (!reload && wrap) begin
                    state_d = IRQ_PENDING;
                end
            end
            IRQ_PENDING: begin
                if (reload) begin
                    state_d = IRQ_IDLE;
                end else if (ack && !wrap) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             limit_we,
    input  logic [CNT_W-1:0] limit_wval,
    input  logic             limit_ack,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             irq
);

    logic [CNT_W-1:0] limit_q;
    logic             wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (limit_we) begin
            limit_q <= limit_wval;
        end
    end

    assign limit = limit_q;

    ivt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (limit_we),
        .limit  (limit_q),
        .count  (count),
        .wrap   (wrap)
    );

    ivt_irq_fsm u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .ack    (limit_ack),
        .reload (limit_we),
        .irq    (irq)
    );

endmodule

// File: rtl/ivt_regdec.sv
module ivt_regdec
    import ivt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 10,
    localparam int CNT_W    = DATA_W - FIELD_LSB
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              rd,
    input  logic                              wr,
    input  logic [NUM_CHAN-1:0][CNT_W-1:0]    count,
    input  logic [NUM_CHAN-1:0][CNT_W-1:0]    limit,
    output logic [NUM_CHAN-1:0]               limit_we,
    output logic [NUM_CHAN-1:0]               limit_ack,
    output logic [DATA_W-1:0]                 rdata
);

    logic                  aligned;
    logic [CHAN_IDX_W-1:0] chan_sel;
    word_kind_e            kind;
    logic [CNT_W-1:0]      field_val;
    logic [DATA_W-1:0]     rdata_q;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        chan_sel = addr[ADDR_W-1:3];
        kind     = word_kind_e'(addr[2]);
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_dec
        always_comb begin
            limit_we[c]  = wr && aligned && (kind == WORD_LIMIT)
                           && (chan_sel == CHAN_IDX_W'(c));
            limit_ack[c] = rd && aligned && (kind == WORD_LIMIT)
                           && (chan_sel == CHAN_IDX_W'(c));
        end
    end

    always_comb begin
        unique case (kind)
            WORD_COUNT: field_val = count[chan_sel];
            WORD_LIMIT: field_val = limit[chan_sel];
            default:    field_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd && aligned) begin
            rdata_q <= {field_val, {FIELD_LSB{1'b0}}};
        end else begin
            rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ival_timer_pair.sv
module ival_timer_pair
    import ivt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CHAN-1:0] irq
);

    localparam int CNT_W = DATA_W - FIELD_LSB;

    logic [NUM_CHAN-1:0][CNT_W-1:0] ch_count;
    logic [NUM_CHAN-1:0][CNT_W-1:0] ch_limit;
    logic [NUM_CHAN-1:0]            ch_limit_we;
    logic [NUM_CHAN-1:0]            ch_limit_ack;
    logic [CNT_W-1:0]               wfield;
    logic                           unused_wdata_low;

    assign wfield           = bus_wdata[DATA_W-1:FIELD_LSB];
    assign unused_wdata_low = ^bus_wdata[FIELD_LSB-1:0];

    ivt_regdec #(
        .DATA_W    (DATA_W),
        .FIELD_LSB (FIELD_LSB)
    ) u_regdec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .count     (ch_count),
        .limit     (ch_limit),
        .limit_we  (ch_limit_we),
        .limit_ack (ch_limit_ack),
        .rdata     (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        ivt_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (us_tick),
            .limit_we   (ch_limit_we[c]),
            .limit_wval (wfield),
            .limit_ack  (ch_limit_ack[c]),
            .count      (ch_count[c]),
            .limit      (ch_limit[c]),
            .irq        (irq[c])
        );
    end

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                us_tick,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_CHAN-1:0] irq
);

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[FIELD_LSB-1:0] == '0);

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    p_misaligned_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[1:0] != 2'b00)) |=> (bus_rdata == '0));

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] LIM_ADDR = ADDR_W'(c * 8 + 4);

        p_set_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(us_tick));

        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[c] && !((bus_rd || bus_wr) && bus_addr == LIM_ADDR)) |=> irq[c]);

        p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[c] && bus_rd && !bus_wr && bus_addr == LIM_ADDR && !us_tick) |=> !irq[c]);

        p_limit_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == LIM_ADDR) |=> !irq[c]);
    end

endmodule

bind ival_timer_pair ivt_checker #(
    .DATA_W    (DATA_W),
    .FIELD_LSB (FIELD_LSB)
) u_ivt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq       (irq)
);

// File: tb/ival_timer_pair_test.sv
module ival_timer_pair_test;

    localparam int DW = 20;
    localparam int FL = 10;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_IQ = 2'd3;

    localparam int NVEC = 26;
    // {op, addr, data, expected irq}
    localparam logic [27:0] VEC [NVEC] = '{
        {OP_WR, 4'h4, 20'h01400, 2'b00},
        {OP_RD, 4'h0, 20'h00400, 2'b00},
        {OP_TK, 4'h0, 20'd2,     2'b00},
        {OP_RD, 4'h0, 20'h00C00, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b00},
        {OP_TK, 4'h0, 20'd2,     2'b00},
        {OP_RD, 4'h0, 20'h00400, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b01},
        {OP_RD, 4'h8, 20'h01400, 2'b00},
        {OP_RD, 4'h4, 20'h01400, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b00},
        {OP_WR, 4'hC, 20'h00C00, 2'b00},
        {OP_TK, 4'h0, 20'd2,     2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b10},
        {OP_WR, 4'h0, 20'hFFC00, 2'b00},
        {OP_RD, 4'h0, 20'h00C00, 2'b00},
        {OP_RD, 4'hC, 20'h00C00, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b00},
        {OP_TK, 4'h0, 20'd4,     2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b11},
        {OP_RD, 4'h8, 20'h00400, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b11},
        {OP_RD, 4'h4, 20'h01400, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b10},
        {OP_RD, 4'hC, 20'h00C00, 2'b00},
        {OP_IQ, 4'h0, 20'h00000, 2'b00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [1:0]    irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    ival_timer_pair #(
        .DATA_W    (DW),
        .FIELD_LSB (FL)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        us_tick = 1'b1;
        repeat (n) @(negedge clk);
        us_tick = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] rv;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq), 32'h0);
        check("R1 rdata in reset", 32'(bus_rdata), 32'h0);
        rst_n = 1'b1;
        bus_read(4'h0, rv); check("R1 count A", 32'(rv), 32'h00400);
        bus_read(4'h4, rv); check("R1 limit A", 32'(rv), 32'h0);
        bus_read(4'h8, rv); check("R1 count B", 32'(rv), 32'h00400);
        bus_read(4'hC, rv); check("R1 limit B", 32'(rv), 32'h0);
        check("R1 irq after reset", 32'(irq), 32'h0);

        // Table: R2 R3 R4 R6 R7 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]    op;
            logic [3:0]    a;
            logic [DW-1:0] d;
            logic [1:0]    ei;
            {op, a, d, ei} = VEC[i];
            unique case (op)
                OP_WR: bus_write(a, d);
                OP_RD: begin
                    bus_read(a, rv);
                    check("R2/R3/R9/R10 table read", 32'(rv), 32'(d));
                end
                OP_TK: ticks(int'(d));
                OP_IQ: check("R6/R7/R10 table irq", 32'(irq), 32'(ei));
                default: ;
            endcase
        end

        // R11: misaligned accesses are ignored
        ticks(2);
        check("R6 both pending", 32'(irq), 32'h3);
        bus_read(4'hD, rv);
        check("R11 misaligned read data", 32'(rv), 32'h0);
        check("R11 misaligned read no ack", 32'(irq), 32'h3);
        bus_write(4'h5, 20'h00800);
        bus_read(4'h4, rv);
        check("R11 misaligned write ignored", 32'(rv), 32'h01400);
        check("R7 limit read clears A only", 32'(irq), 32'h2);

        // R8: limit write clears pending and restarts count
        bus_write(4'hC, 20'h00C00);
        check("R8 limit write clears irq", 32'(irq), 32'h0);
        bus_read(4'h8, rv);
        check("R8 count restarts at 1", 32'(rv), 32'h00400);

        // R7: wrap and clearing read in the same cycle
        ticks(1);
        @(negedge clk);
        us_tick = 1'b1; bus_rd = 1'b1; bus_addr = 4'hC;
        @(negedge clk);
        us_tick = 1'b0; bus_rd = 1'b0;
        check("R7 wrap beats ack", 32'(irq[1]), 32'h1);
        check("R7 limit read data", 32'(bus_rdata), 32'h00C00);

        // R5: zero limit free-runs and rolls over
        bus_write(4'h4, 20'h00000);
        ticks(1022);
        bus_read(4'h0, rv);
        check("R5 count at top", 32'(rv), 32'hFFC00);
        check("R5 no irq", 32'(irq[0]), 32'h0);
        ticks(1);
        bus_read(4'h0, rv);
        check("R5 rollover to zero", 32'(rv), 32'h0);
        check("R5 no irq at rollover", 32'(irq[0]), 32'h0);

        // R3: no tick, no advance
        repeat (5) @(negedge clk);
        bus_read(4'h0, rv);
        check("R3 hold without tick", 32'(rv), 32'h0);

        // R4: limit 1 wraps every tick
        bus_write(4'h4, 20'h00400);
        ticks(1);
        check("R4 limit 1 irq", 32'(irq[0]), 32'h1);
        bus_read(4'h4, rv);
        check("R7 ack clears", 32'(irq[0]), 32'h0);
        bus_read(4'h0, rv);
        check("R4 count back to 1", 32'(rv), 32'h00400);

        // R8: write wins over a same-cycle wrap
        @(negedge clk);
        us_tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 20'h00400;
        @(negedge clk);
        us_tick = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        check("R8 write beats wrap", 32'(irq[0]), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule